// File: doc/BRIEF.md
# Storage Key Reference and Change Updater

This block holds one storage key for every 4 KiB frame of absolute memory and updates it on each translated access. When the translation path presents an absolute address, an access type and a valid strobe, the block reads the key of the addressed frame, sets its reference bit, and sets its change bit on stores. It then writes the key back. The request also carries the write permission the translation path intends to cache for the page. The block returns that permission. For loads and instruction fetches it withholds the permission while the frame's change bit is still clear, so that the first store to the page is routed back through this block and the change bit gets recorded.

Each request takes one key read cycle and one write-back cycle. A new request may be issued only after the done pulse of the previous one. Addresses at or beyond the configured memory size touch no key and pass the permission through unchanged. A synchronous clear input zeroes every key. With the done pulse the block also returns the key as it stood before the update, so the translation path can see the frame's earlier history.

Top module: `skey_updater`

## Requirements
- R1: The key used by a request is selected by the absolute address shifted right by 12 bits. Accesses anywhere inside the same 4 KiB frame share one key, and distinct frames have distinct keys.
- R2: Every in-range access of any type sets bit 2 (reference) of the addressed key.
- R3: A store (type code 2'b01) sets bit 1 (change) of the addressed key. Loads (2'b00) and fetches (2'b10, and 2'b11 which is treated as a fetch) leave the change bit as it was.
- R4: For an in-range load or fetch whose key has the change bit clear, `permOut` is 0. If the change bit is set, `permOut` equals the request's `permIn`.
- R5: For an in-range store, `permOut` equals the request's `permIn`.
- R6: A request whose address is at or above NUM_PAGES × 4096 (262144 by default) changes no key. It returns `permOut` equal to `permIn` and `keyOut` equal to 0.
- R7: `done` is high for exactly one cycle, during the third cycle after the clock edge that accepts the request. A `reqValid` raised before that done pulse is ignored.
- R8: With `done`, `keyOut` carries the 8-bit key of the frame as it was before this request's update. Bit 1 is change, bit 2 is reference, bit 3 is fetch-protect, bits 7:4 are access control, and bit 0 is always 0.
- R9: Reset zeroes all keys. A one-cycle `keyClr` while no request is in progress also zeroes all keys and produces no `done`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| keyClr | input | 1 | Zero every key (honoured when idle) |
| reqValid | input | 1 | Request strobe, one cycle |
| reqAddr | input | ADDR_W | Absolute byte address |
| reqType | input | 2 | 00 load, 01 store, 10 or 11 instruction fetch |
| permIn | input | 1 | Write permission proposed by the translation path |
| permOut | output | 1 | Write permission after the change-bit rule, valid with done |
| keyOut | output | 8 | Key before update, valid with done |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that the translation path never raises `reqValid` or `keyClr` while a request is in flight, and that `keyClr` and `reqValid` are not raised together. The bench keeps to this by waiting for each done pulse before issuing anything new. There is one deliberate exception: a stray `reqValid` raised mid-request to show that it is ignored. That case is consistent with the assertions, because the controller does not accept it. The sweep visits every frame with every access type and both permission values. It compares each result with a key model kept in the bench, and then probes addresses past the memory end that would alias low frames if they were not gated.

// File: rtl/skey_pkg.sv
package skey_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD      = 2'b00,
    ACC_STORE     = 2'b01,
    ACC_FETCH     = 2'b10,
    ACC_FETCH_ALT = 2'b11
  } accType_e;

  localparam int KEY_W   = 8;
  localparam int CHG_BIT = 1;
  localparam int REF_BIT = 2;

  typedef struct packed {
    logic latchReq;
    logic readKey;
    logic writeBack;
    logic clearAll;
  } ctrlStrobe_t;

endpackage

// File: rtl/skey_ctrl.sv
module skey_ctrl
  import skey_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reqValid,
  input  logic        keyClr,
  output ctrlStrobe_t strb
);

  typedef enum logic [1:0] {ST_IDLE, ST_READ, ST_WRITE} state_e;

  state_e stateQ, stateD;

  always_comb begin
    stateD = stateQ;
    strb   = '0;
    unique case (stateQ)
      ST_IDLE: begin
        if (keyClr) begin
          strb.clearAll = 1'b1;
        end else if (reqValid) begin
          strb.latchReq = 1'b1;
          stateD        = ST_READ;
        end
      end
      ST_READ: begin
        strb.readKey = 1'b1;
        stateD       = ST_WRITE;
      end
      ST_WRITE: begin
        strb.writeBack = 1'b1;
        stateD         = ST_IDLE;
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) stateQ <= ST_IDLE;
    else        stateQ <= stateD;
  end

  // R7: an accepted request is read in the next cycle, then written back
  a_r7_latch_then_read: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchReq |=> strb.readKey);
  a_r7_read_then_write: assert property (@(posedge clk) disable iff (!rst_n)
    strb.readKey |=> strb.writeBack);
  // R7: no acceptance directly after an acceptance
  a_r7_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    strb.latchReq |=> !strb.latchReq);

endmodule

// File: rtl/skey_datapath.sv
module skey_datapath
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqType,
  input  logic              permIn,
  output logic              permOut,
  output logic [KEY_W-1:0]  keyOut,
  output logic              done
);

  localparam int IDX_W = (NUM_PAGES > 1) ? $clog2(NUM_PAGES) : 1;
  localparam logic [ADDR_W:0] MEM_BYTES = (ADDR_W+1)'(NUM_PAGES) << PAGE_BITS;

  logic [KEY_W-1:0] keyMem [NUM_PAGES];

  logic [IDX_W-1:0] idxQ;
  logic             inRangeQ;
  logic             isStoreQ;
  logic             permQ;
  logic [KEY_W-1:0] keyRdQ;
  logic [KEY_W-1:0] keyNew;
  logic             permNew;

  // request capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idxQ     <= '0;
      inRangeQ <= 1'b0;
      isStoreQ <= 1'b0;
      permQ    <= 1'b0;
    end else if (strb.latchReq) begin
      idxQ     <= reqAddr[PAGE_BITS +: IDX_W];
      inRangeQ <= ({1'b0, reqAddr} < MEM_BYTES);
      isStoreQ <= (reqType == ACC_STORE);
      permQ    <= permIn;
    end
  end

  // key read cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      keyRdQ <= '0;
    end else if (strb.readKey) begin
      keyRdQ <= inRangeQ ? keyMem[idxQ] : '0;
    end
  end

  // modify
  always_comb begin
    keyNew          = keyRdQ;
    keyNew[0]       = 1'b0;
    keyNew[REF_BIT] = 1'b1;
    if (isStoreQ) keyNew[CHG_BIT] = 1'b1;
    permNew = permQ;
    if (inRangeQ && !isStoreQ && !keyRdQ[CHG_BIT]) permNew = 1'b0;
  end

  // key storage with write-back and bulk clear
  always_ff @(posedge clk) begin
    if (!rst_n || strb.clearAll) begin
      for (int i = 0; i < NUM_PAGES; i++) keyMem[i] <= '0;
    end else if (strb.writeBack && inRangeQ) begin
      keyMem[idxQ] <= keyNew;
    end
  end

  // result registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done    <= 1'b0;
      permOut <= 1'b0;
      keyOut  <= '0;
    end else begin
      done <= strb.writeBack;
      if (strb.writeBack) begin
        permOut <= permNew;
        keyOut  <= keyRdQ;
      end
    end
  end

  // R2: reference bit present after any in-range write-back
  a_r2_ref_set: assert property (@(posedge clk) disable iff (!rst_n)
    strb.writeBack && inRangeQ |=> keyMem[$past(idxQ)][REF_BIT]);
  // R3: change bit present after a store write-back
  a_r3_store_marks_change: assert property (@(posedge clk) disable iff (!rst_n)
    strb.writeBack && inRangeQ && isStoreQ |=> keyMem[$past(idxQ)][CHG_BIT]);
  // R3: non-store keeps the change bit as it was read
  a_r3_read_keeps_change: assert property (@(posedge clk) disable iff (!rst_n)
    strb.writeBack && inRangeQ && !isStoreQ
      |=> keyMem[$past(idxQ)][CHG_BIT] == $past(keyRdQ[CHG_BIT]));
  // R4: a clean page never yields write permission on a read access
  a_r4_clean_read_withholds: assert property (@(posedge clk) disable iff (!rst_n)
    strb.writeBack && inRangeQ && !isStoreQ && !keyRdQ[CHG_BIT] |=> !permOut);
  // R6: out-of-range requests pass permission and report a zero key
  a_r6_outrange_passes: assert property (@(posedge clk) disable iff (!rst_n)
    strb.writeBack && !inRangeQ |=> (permOut == $past(permQ)) && (keyOut == '0));
  // R7: done is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9: bulk clear empties the key array
  a_r9_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    strb.clearAll |=> (keyMem[0] == '0) && (keyMem[NUM_PAGES-1] == '0));
  // R8: bit 0 of the reported key is never set
  a_r8_bit0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !keyOut[0]);

endmodule

// File: rtl/skey_updater.sv
module skey_updater
  import skey_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int PAGE_BITS = 12,
  parameter int NUM_PAGES = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              keyClr,
  input  logic              reqValid,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [1:0]        reqType,
  input  logic              permIn,
  output logic              permOut,
  output logic [7:0]        keyOut,
  output logic              done
);

  ctrlStrobe_t strb;

  skey_ctrl ctrl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .reqValid (reqValid),
    .keyClr   (keyClr),
    .strb     (strb)
  );

  skey_datapath #(
    .ADDR_W    (ADDR_W),
    .PAGE_BITS (PAGE_BITS),
    .NUM_PAGES (NUM_PAGES)
  ) dp_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .strb    (strb),
    .reqAddr (reqAddr),
    .reqType (reqType),
    .permIn  (permIn),
    .permOut (permOut),
    .keyOut  (keyOut),
    .done    (done)
  );

endmodule

// File: tb/skey_updater_tb.sv
`timescale 1ns/1ps
module skey_updater_tb_top;

  localparam int NP = 64;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        keyClr = 1'b0;
  logic        reqValid = 1'b0;
  logic [31:0] reqAddr = '0;
  logic [1:0]  reqType = '0;
  logic        permIn = 1'b0;
  logic        permOut;
  logic [7:0]  keyOut;
  logic        done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [7:0] model [NP];

  always #4 clk = ~clk;

  skey_updater dut_i (
    .clk(clk), .rst_n(rst_n), .keyClr(keyClr), .reqValid(reqValid),
    .reqAddr(reqAddr), .reqType(reqType), .permIn(permIn),
    .permOut(permOut), .keyOut(keyOut), .done(done)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // issue one request and check timing, key and permission (R1..R8)
  task automatic doReq(input logic [31:0] a, input logic [1:0] t, input bit p);
    bit inR = (a < 32'(NP * 4096));
    int idx = int'(a >> 12);
    logic [7:0] expKey = inR ? model[idx % NP] : 8'h00;
    bit expPerm = p;
    if (inR && t != 2'b01 && !expKey[1]) expPerm = 1'b0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqType = t; permIn = p;
    @(negedge clk);
    reqValid = 1'b0;
    check(done == 1'b0, "R7 done early 1", 32'(done), 0);
    @(negedge clk);
    check(done == 1'b0, "R7 done early 2", 32'(done), 0);
    @(negedge clk);
    check(done == 1'b1, "R7 done missing", 32'(done), 1);
    check(keyOut == expKey, inR ? "R8 R1 key before update" : "R6 key out of range",
          32'(keyOut), 32'(expKey));
    if (inR) check(permOut == expPerm, (t == 2'b01) ? "R5 store perm" : "R4 read perm",
                   32'(permOut), 32'(expPerm));
    else     check(permOut == p, "R6 perm passthrough", 32'(permOut), 32'(p));
    @(negedge clk);
    check(done == 1'b0, "R7 done width", 32'(done), 0);
    if (inR) begin
      model[idx][2] = 1'b1;                  // R2
      if (t == 2'b01) model[idx][1] = 1'b1;  // R3
    end
  endtask

  initial begin
    #(8 * 150000);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NP; i++) model[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0, "R7 reset done", 32'(done), 0);
    check(keyOut == 8'h00, "R9 reset keyOut", 32'(keyOut), 0);

    // full sweep: each frame, every access type, varied offset (R1..R5, R8)
    for (int pg = 0; pg < NP; pg++) begin
      logic [31:0] base = 32'(pg) << 12;
      doReq(base | 32'((pg * 37) & 12'hfff), 2'b00, 1'b1);
      doReq(base | 32'hfff, (pg % 2 == 0) ? 2'b10 : 2'b11, 1'b1);
      doReq(base | 32'((pg * 91) & 12'hfff), 2'b01, pg[2]);
      doReq(base, 2'b00, 1'b1);
      doReq(base | 32'h800, 2'b10, pg[0]);
    end

    // out-of-range, including values aliasing low frames (R6)
    doReq(32'(NP * 4096), 2'b01, 1'b1);
    doReq(32'(NP * 4096) + 32'h1005, 2'b00, 1'b0);
    doReq(32'hffff_ffff, 2'b01, 1'b0);
    doReq(32'h0000_0010, 2'b00, 1'b1);
    doReq(32'h0000_1010, 2'b00, 1'b1);

    // clear: keys gone, no done (R9)
    @(negedge clk);
    keyClr = 1'b1;
    @(negedge clk);
    keyClr = 1'b0;
    check(done == 1'b0, "R9 clear no done", 32'(done), 0);
    @(negedge clk);
    check(done == 1'b0, "R9 clear no done later", 32'(done), 0);
    for (int i = 0; i < NP; i++) model[i] = 8'h00;
    doReq(32'h0000_3000, 2'b00, 1'b1);
    doReq(32'(NP - 1) << 12, 2'b10, 1'b1);

    // stray valid while busy is ignored (R7)
    @(negedge clk);
    reqValid = 1'b1; reqAddr = 32'h0000_5000; reqType = 2'b00; permIn = 1'b1;
    @(negedge clk);
    reqAddr = 32'h0000_7000; reqType = 2'b01;
    @(negedge clk);
    reqValid = 1'b0;
    @(negedge clk);
    check(done == 1'b1, "R7 first done", 32'(done), 1);
    @(negedge clk);
    check(done == 1'b0, "R7 stray not accepted", 32'(done), 0);
    @(negedge clk);
    check(done == 1'b0, "R7 stray not accepted 2", 32'(done), 0);
    model[5][2] = 1'b1;
    doReq(32'h0000_7000, 2'b00, 1'b1);  // expects untouched key: R7
    doReq(32'h0000_5000, 2'b00, 1'b1);

    // reset zeroes keys (R9)
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NP; i++) model[i] = 8'h00;
    doReq(32'h0000_5000, 2'b01, 1'b1);
    doReq(32'h0000_5abc, 2'b00, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule